// File: doc/BRIEF.md
# Isochronous Timestamp Generator and Queue

This block produces presentation timestamps for an isochronous audio/video transmitter. When the special timestamp mode is on, each rising edge of the frame-sync input samples the 16-bit bus cycle time and turns it into a timestamp that points a programmed number of bus cycles into the future. The timestamp waits in a four-entry queue.

The queue gives up its oldest entry only when a packet that carries payload is sent. Empty packets leave pending timestamps where they are. At send time the entry at the head is compared with the current cycle. An entry that no longer points at least one cycle ahead is dropped, and the next entry is tried for the same packet. Packet assembly and encryption are handled elsewhere.

Top module: `iso_ts_queue`

## Requirements
- R1: After reset the queue is empty and `ts_valid_o`, `discard_o` and `overflow_o` are 0.
- R2: A timestamp is captured only on a rising edge of `fsync_i`, sampled at a clock edge, while `mode_en_i` is 1. A level that stays high gives one capture. An edge seen while `mode_en_i` is 0 gives none.
- R3: The captured timestamp has bits [15:12] = (`cyc_time_i[15:12]` + `delay_i` + 2) mod 16 and bits [11:0] = `cyc_time_i[11:0]`, both taken in the capture cycle.
- R4: The queue holds up to 4 timestamps and sends them oldest first.
- R5: A capture when no slot is free is dropped, and `overflow_o` is set and stays 1 until reset. A slot freed by a send in the same cycle counts as free.
- R6: Entries leave only in a cycle with `send_req_i`=1 and `send_nonempty_i`=1. A request with `send_nonempty_i`=0 leaves the queue unchanged. `ts_valid_o` and `ts_o` show the sent entry for one cycle, in the cycle after the request.
- R7: At a send, an entry whose cycle distance (`ts[15:12]` − `cyc_time_i[15:12]`) mod 16 is 0 is stale. It is removed without being sent, and `discard_o` pulses in the cycle after the request.
- R8: Within one send, stale entries at the head are all removed, and the first entry after them that is not stale is sent with that packet.
- R9: A timestamp captured in a cycle can first be sent in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_en_i | input | 1 | Enables timestamp generation |
| fsync_i | input | 1 | Frame sync; its rising edge captures a timestamp |
| cyc_time_i | input | 16 | Current bus cycle time |
| delay_i | input | 4 | Programmed delay, in cycles |
| send_req_i | input | 1 | A packet is being sent this cycle |
| send_nonempty_i | input | 1 | The packet being sent carries payload |
| ts_o | output | 16 | Timestamp attached to the packet |
| ts_valid_o | output | 1 | `ts_o` is valid |
| discard_o | output | 1 | One or more stale entries were dropped |
| overflow_o | output | 1 | Sticky flag: a capture was lost because the queue was full |

## Verification
A frame-sync capture and a payload send can land in the same cycle. This matters most when the queue is full. The bench fills the queue and then raises `fsync_i` and a non-empty send request together. It then checks three things: the head is sent, the new timestamp is accepted without setting overflow, and the new timestamp drains last behind the other three. On an empty queue the same coincidence must send nothing, and the new entry must go out with the next request.

// File: rtl/iso_ts_pkg.sv
package iso_ts_pkg;
  localparam int unsigned TS_W = 16;  // timestamp / cycle-time width
  localparam int unsigned CF_W = 4;   // cycle field at the top of the word
  localparam int unsigned LO_W = TS_W - CF_W;
  typedef logic [TS_W-1:0] ts_t;
  typedef logic [CF_W-1:0] cyc_t;
endpackage

// File: rtl/iso_ts_build.sv
module iso_ts_build
  import iso_ts_pkg::*;
#(
  parameter int unsigned MODE_OFS = 2
) (
  input  ts_t  cyc_time_i,
  input  cyc_t delay_i,
  input  logic mode_en_i,
  output ts_t  ts_o
);
  cyc_t ofs;
  assign ofs = mode_en_i ? cyc_t'(MODE_OFS) : '0;
  // cycle field wraps mod 2**CF_W, offset field passes through
  assign ts_o = {cyc_time_i[TS_W-1 -: CF_W] + delay_i + ofs, cyc_time_i[LO_W-1:0]};
endmodule

// File: rtl/iso_ts_fifo.sv
module iso_ts_fifo
  import iso_ts_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   push_i,
  input  ts_t                    push_data_i,
  input  logic [CNT_W-1:0]       pop_n_i,
  output logic [CNT_W-1:0]       count_o,
  output logic [DEPTH-1:0][TS_W-1:0] peek_o,
  output logic [DEPTH-1:0]       valid_o
);
  logic [DEPTH-1:0][TS_W-1:0] mem_q;
  logic [PTR_W-1:0] head_q;
  logic [CNT_W-1:0] count_q;
  logic [PTR_W-1:0] wr_ptr;

  assign wr_ptr  = PTR_W'(head_q + PTR_W'(count_q));
  assign count_o = count_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_peek
    assign peek_o[g]  = mem_q[PTR_W'(head_q + PTR_W'(g))];
    assign valid_o[g] = (CNT_W'(g) < count_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q   <= '0;
      head_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) mem_q[wr_ptr] <= push_data_i;
      head_q  <= PTR_W'(head_q + PTR_W'(pop_n_i));
      count_q <= count_q - pop_n_i + CNT_W'(push_i);
    end
  end

  assert_count_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  assert_pop_le_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_n_i <= count_q);
endmodule

// File: rtl/iso_ts_select.sv
module iso_ts_select
  import iso_ts_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][TS_W-1:0] peek_i,
  input  logic [DEPTH-1:0]       valid_i,
  input  cyc_t                   cur_cyc_i,
  output logic                   found_o,
  output ts_t                    data_o,
  output logic [CNT_W-1:0]       pop_n_o,
  output logic                   drop_any_o
);
  logic done;
  always_comb begin
    found_o = 1'b0;
    data_o  = '0;
    pop_n_o = '0;
    done    = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (valid_i[i] && !done) begin
        pop_n_o = CNT_W'(i + 1);
        // distance 0 mod 16 means less than one cycle ahead
        if (peek_i[i][TS_W-1 -: CF_W] != cur_cyc_i) begin
          found_o = 1'b1;
          data_o  = peek_i[i];
          done    = 1'b1;
        end
      end
    end
    drop_any_o = found_o ? (pop_n_o > CNT_W'(1)) : (pop_n_o != '0);
  end
endmodule

// File: rtl/iso_ts_queue.sv
module iso_ts_queue
  import iso_ts_pkg::*;
#(
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned MODE_OFS = 2,
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mode_en_i,
  input  logic        fsync_i,
  input  logic [15:0] cyc_time_i,
  input  logic [3:0]  delay_i,
  input  logic        send_req_i,
  input  logic        send_nonempty_i,
  output logic [15:0] ts_o,
  output logic        ts_valid_o,
  output logic        discard_o,
  output logic        overflow_o
);
  logic fsync_q, rise, send_fire, push;
  ts_t new_ts, sel_ts;
  logic sel_found, sel_drop;
  logic [CNT_W-1:0] sel_pop, pop_n, count;
  logic [DEPTH-1:0][TS_W-1:0] peek;
  logic [DEPTH-1:0] valid;
  logic [CNT_W:0] after_pop;

  assign rise      = fsync_i && !fsync_q && mode_en_i;
  assign send_fire = send_req_i && send_nonempty_i;
  assign pop_n     = send_fire ? sel_pop : '0;
  assign after_pop = {1'b0, count} - {1'b0, pop_n};
  assign push      = rise && (after_pop < (CNT_W+1)'(DEPTH));

  iso_ts_build #(.MODE_OFS(MODE_OFS)) u_build (
    .cyc_time_i(cyc_time_i), .delay_i(delay_i), .mode_en_i(mode_en_i), .ts_o(new_ts));

  iso_ts_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .push_data_i(new_ts),
    .pop_n_i(pop_n), .count_o(count), .peek_o(peek), .valid_o(valid));

  iso_ts_select #(.DEPTH(DEPTH)) u_sel (
    .peek_i(peek), .valid_i(valid), .cur_cyc_i(cyc_time_i[TS_W-1 -: CF_W]),
    .found_o(sel_found), .data_o(sel_ts), .pop_n_o(sel_pop), .drop_any_o(sel_drop));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsync_q    <= 1'b0;
      ts_o       <= '0;
      ts_valid_o <= 1'b0;
      discard_o  <= 1'b0;
      overflow_o <= 1'b0;
    end else begin
      fsync_q    <= fsync_i;
      ts_valid_o <= send_fire && sel_found;
      discard_o  <= send_fire && sel_drop;
      if (send_fire && sel_found) ts_o <= sel_ts;
      if (rise && !push) overflow_o <= 1'b1;
    end
  end

  assert_valid_needs_payload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_valid_o |-> $past(send_req_i && send_nonempty_i));
  assert_discard_needs_payload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |-> $past(send_req_i && send_nonempty_i));
  assert_sent_is_fresh_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_valid_o |-> (ts_o[15:12] != $past(cyc_time_i[15:12])));
  assert_overflow_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(overflow_o) |-> overflow_o);
  assert_no_pop_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(send_req_i && send_nonempty_i) |=> $stable(u_fifo.head_q));
endmodule

// File: tb/iso_ts_queue_tb.sv
module iso_ts_queue_tb;
  logic clk = 0, rst_n = 0;
  logic mode_en = 0, fsync = 0, send_req = 0, send_ne = 0;
  logic [15:0] cyc = 0;
  logic [3:0] dly = 0;
  logic [15:0] ts;
  logic ts_valid, discard, overflow;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  iso_ts_queue u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_en_i(mode_en), .fsync_i(fsync),
    .cyc_time_i(cyc), .delay_i(dly), .send_req_i(send_req),
    .send_nonempty_i(send_ne), .ts_o(ts), .ts_valid_o(ts_valid),
    .discard_o(discard), .overflow_o(overflow));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_ts(logic [15:0] c, logic [3:0] d);
    logic [3:0] hi;
    hi = c[15:12] + d + 4'd2;
    return {hi, c[11:0]};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; fsync = 0; send_req = 0; send_ne = 0; mode_en = 1;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic sync(logic [15:0] c, logic [3:0] d);
    fsync = 1; cyc = c; dly = d;
    @(negedge clk);
    fsync = 0;
    @(negedge clk);
  endtask

  // one send request; outputs sampled in the following cycle
  task automatic send(logic [15:0] cur, logic ne);
    send_req = 1; send_ne = ne; cyc = cur;
    @(negedge clk);
    send_req = 0; send_ne = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ts_valid", ts_valid, 0);
    chk("R1 discard", discard, 0);
    chk("R1 overflow", overflow, 0);
    send(16'h0000, 1);
    chk("R1 empty queue", ts_valid, 0);
  endtask

  task automatic t_format();
    do_reset();
    sync(16'h3ABC, 4'd4);
    sync(16'hE123, 4'd3);
    send(16'h3000, 1);
    chk("R3 basic ts", ts, exp_ts(16'h3ABC, 4'd4));
    chk("R3 basic valid", ts_valid, 1);
    @(negedge clk);
    chk("R6 one-cycle valid", ts_valid, 0);
    send(16'hE000, 1);
    chk("R3 wrap ts", ts, 16'h3123);
  endtask

  task automatic t_mode_level();
    do_reset();
    mode_en = 0;
    sync(16'h1111, 4'd1);
    mode_en = 1;
    send(16'h0000, 1);
    chk("R2 mode off no capture", ts_valid, 0);
    fsync = 1; cyc = 16'h1222; dly = 4'd1;
    repeat (3) @(negedge clk);
    fsync = 0;
    @(negedge clk);
    send(16'h0000, 1);
    chk("R2 level first", ts, exp_ts(16'h1222, 4'd1));
    send(16'h0000, 1);
    chk("R2 level single capture", ts_valid, 0);
  endtask

  task automatic t_hold_empty();
    do_reset();
    sync(16'h2001, 4'd2);
    send(16'h2000, 0);
    chk("R6 empty packet no ts", ts_valid, 0);
    send(16'h2000, 1);
    chk("R6 held entry sent", ts, exp_ts(16'h2001, 4'd2));
    chk("R6 held entry valid", ts_valid, 1);
  endtask

  task automatic t_order_overflow();
    do_reset();
    for (int i = 0; i < 5; i++) sync(16'h0010 + 16'(i), 4'd4);
    chk("R5 overflow set", overflow, 1);
    for (int i = 0; i < 4; i++) begin
      send(16'h0000, 1);
      chk("R4 oldest first", ts, exp_ts(16'h0010 + 16'(i), 4'd4));
    end
    send(16'h0000, 1);
    chk("R5 fifth dropped", ts_valid, 0);
    chk("R5 overflow sticky", overflow, 1);
  endtask

  task automatic t_stale();
    do_reset();
    sync(16'h1000, 4'd0);
    send(16'h3555, 1);
    chk("R7 stale discard", discard, 1);
    chk("R7 stale not sent", ts_valid, 0);
    send(16'h3555, 1);
    chk("R7 stale removed", discard, 0);
    sync(16'h1000, 4'd0);
    sync(16'h2111, 4'd0);
    send(16'h3000, 1);
    chk("R8 discard flagged", discard, 1);
    chk("R8 next sent", ts_valid, 1);
    chk("R8 next value", ts, 16'h4111);
  endtask

  task automatic t_same_cycle();
    do_reset();
    for (int i = 1; i <= 4; i++) sync(16'(i), 4'd4);
    fsync = 1; cyc = 16'h0005; dly = 4'd4; send_req = 1; send_ne = 1;
    @(negedge clk);
    fsync = 0; send_req = 0; send_ne = 0;
    chk("R5 coincident send head", ts, 16'h6001);
    chk("R5 freed slot no overflow", overflow, 0);
    for (int i = 2; i <= 5; i++) begin
      send(16'h0000, 1);
      chk("R5 drain incl new entry", ts, 16'h6000 + 16'(i));
    end
    send(16'h0000, 1);
    chk("R4 queue drained", ts_valid, 0);
    do_reset();
    fsync = 1; cyc = 16'h0777; dly = 4'd1; send_req = 1; send_ne = 1;
    @(negedge clk);
    fsync = 0; send_req = 0; send_ne = 0;
    chk("R9 not sendable same cycle", ts_valid, 0);
    @(negedge clk);
    send(16'h0000, 1);
    chk("R9 sent next", ts, exp_ts(16'h0777, 4'd1));
  endtask

  initial begin
    t_reset();
    t_format();
    t_mode_level();
    t_hold_empty();
    t_order_overflow();
    t_stale();
    t_same_cycle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule